// File: doc/BRIEF.md
# Shared Endpoint IN-Token Responder

This block decides how a USB device function answers an IN token aimed at one of two interrupt endpoints that share a single transmit buffer. A processor writes one 8-bit control register that holds the data PID choice, which endpoint currently owns the shared buffer, a transmit enable, a force-resume request and a 4-bit byte count. The token side supplies the decoded endpoint number with a one-cycle strobe, plus the buffer-busy flag and the enable and stall bits of both endpoints.

One clock after a token to either endpoint, the block presents a registered response for exactly one cycle. The response is one of four kinds: no answer (timeout), a DATA packet carrying the chosen PID and byte count, a NAK, or a STALL. A token to the endpoint that does not own the buffer is answered with NAK even when everything else would allow data. The force-resume bit is passed straight out as a K-state request for remote wake-up. Serial encoding, NRZI, CRC and bit stuffing are handled elsewhere.

Top module: `shared_ep_in_responder`

## Requirements
- R1: After reset the register reads 0x00, rspValid is 0 and kStateReq is 0.
- R2: A register write is visible on regRdData from the next cycle with exactly the written value. The layout is: bit 7 data PID (0 = DATA0, 1 = DATA1), bit 6 buffer owner (0 = endpoint 1, 1 = endpoint 2), bit 5 transmit enable, bit 4 force resume, bits 3..0 byte count.
- R3: A token to an enabled, unstalled endpoint that owns the buffer, with transmit enable 1 and bufBusy 0, gives rspKind = 2'b01 (DATA) with rspPid equal to register bit 7 and rspCount equal to bits 3..0, including a count of 0.
- R4: A token to an enabled, unstalled endpoint gives rspKind = 2'b10 (NAK) when transmit enable is 0 or bufBusy is 1.
- R5: A token to an enabled, unstalled endpoint that does not own the buffer gives NAK even when transmit enable is 1 and bufBusy is 0.
- R6: A token to an enabled endpoint whose stall bit is set gives rspKind = 2'b11 (STALL), regardless of busy, transmit enable and owner.
- R7: A token to a disabled endpoint gives rspValid = 1 with rspKind = 2'b00 (no answer, timeout).
- R8: rspValid is 1 in exactly the cycle after a token strobe whose tokEp is 1 or 2 and is 0 otherwise; tokens to other endpoint numbers produce no response. epEnable/epStall bit 0 belongs to endpoint 1, bit 1 to endpoint 2.
- R9: The data PID bit changes only by a register write; sending DATA never toggles it.
- R10: kStateReq equals the force-resume bit from the cycle after the write and does not alter any response.
- R11: On every response that is not DATA, rspPid and rspCount are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write value |
| regRdData | output | 8 | Control register read value |
| tokValid | input | 1 | IN token strobe, one cycle |
| tokEp | input | 4 | Decoded endpoint number of the token |
| bufBusy | input | 1 | Shared buffer busy / full flag |
| epEnable | input | 2 | Endpoint enables (bit 0 = EP1, bit 1 = EP2) |
| epStall | input | 2 | Endpoint stall bits (bit 0 = EP1, bit 1 = EP2) |
| rspValid | output | 1 | Response valid, one cycle after the token |
| rspKind | output | 2 | 00 none, 01 DATA, 10 NAK, 11 STALL |
| rspPid | output | 1 | 0 DATA0, 1 DATA1 (DATA only) |
| rspCount | output | 4 | Byte count (DATA only) |
| kStateReq | output | 1 | Request to drive K state for remote wake-up |

## Verification
The bench sweeps every endpoint number 0..3 against every combination of enables, stalls, busy, transmit enable, owner and PID, with byte counts cycling through 0..15, and computes the expected answer from the priority order. A design that checked only busy and transmit enable would send DATA to the endpoint that does not own the buffer; one that let NAK win over STALL, or answered a disabled endpoint, would show the wrong kind. It also watches for a response to endpoints 0 and 3, a valid held past one cycle, a PID that flips after DATA, and stale PID or count on NAK and STALL.

// File: rtl/epresp_pkg.sv
package epresp_pkg;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'b00,
    RSP_DATA  = 2'b01,
    RSP_NAK   = 2'b10,
    RSP_STALL = 2'b11
  } rspKind_e;

  // Strobes from the decision logic to the datapath
  typedef struct packed {
    logic     regLoad;
    logic     rspLoad;
    logic     sendData;
    rspKind_e kind;
  } ctrlStrobe_t;

endpackage

// File: rtl/epresp_ctrl.sv
module epresp_ctrl
  import epresp_pkg::*;
#(
  parameter int EP_W    = 4,
  parameter int NUM_EP  = 2,
  parameter int EP_BASE = 1
) (
  input  logic              regWrEn,
  input  logic              tokValid,
  input  logic [EP_W-1:0]   tokEp,
  input  logic              bufBusy,
  input  logic [NUM_EP-1:0] epEnable,
  input  logic [NUM_EP-1:0] epStall,
  input  logic              txEn,
  input  logic [SEL_W-1:0]  ownerSel,
  output ctrlStrobe_t       strobe
);
  localparam int SEL_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1;

  logic [NUM_EP-1:0] hit;
  logic [NUM_EP-1:0] owns;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_EP; gi++) begin : g_ep
      assign hit[gi]  = tokValid && (tokEp == EP_W'(EP_BASE + gi));
      assign owns[gi] = (ownerSel == SEL_W'(gi));
    end
  endgenerate

  logic     anyHit, hitEn, hitStall, hitOwns;
  rspKind_e kind;

  always_comb begin
    anyHit   = |hit;
    hitEn    = |(hit & epEnable);
    hitStall = |(hit & epStall);
    hitOwns  = |(hit & owns);
    if (!hitEn)                 kind = RSP_NONE;
    else if (hitStall)          kind = RSP_STALL;
    else if (!txEn || bufBusy)  kind = RSP_NAK;
    else if (!hitOwns)          kind = RSP_NAK;
    else                        kind = RSP_DATA;
  end

  always_comb begin
    strobe.regLoad  = regWrEn;
    strobe.rspLoad  = anyHit;
    strobe.kind     = anyHit ? kind : RSP_NONE;
    strobe.sendData = anyHit && (kind == RSP_DATA);
  end
endmodule

// File: rtl/epresp_datapath.sv
module epresp_datapath
  import epresp_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] ctrlReg,
  output logic             rspValid,
  output logic [1:0]       rspKind,
  output logic             rspPid,
  output logic [CNT_W-1:0] rspCount
);
  localparam int REG_W   = CNT_W + 4;
  localparam int PID_BIT = CNT_W + 3;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (strobe.regLoad) begin
      ctrlReg <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspKind  <= RSP_NONE;
      rspPid   <= 1'b0;
      rspCount <= '0;
    end else begin
      rspValid <= strobe.rspLoad;
      rspKind  <= strobe.kind;
      rspPid   <= strobe.sendData ? ctrlReg[PID_BIT] : 1'b0;
      rspCount <= strobe.sendData ? ctrlReg[CNT_W-1:0] : '0;
    end
  end
endmodule

// File: rtl/shared_ep_in_responder.sv
module shared_ep_in_responder
  import epresp_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int EP_W    = 4,
  parameter int EP_BASE = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [CNT_W+3:0]   regWrData,
  output logic [CNT_W+3:0]   regRdData,
  input  logic               tokValid,
  input  logic [EP_W-1:0]    tokEp,
  input  logic               bufBusy,
  input  logic [1:0]         epEnable,
  input  logic [1:0]         epStall,
  output logic               rspValid,
  output logic [1:0]         rspKind,
  output logic               rspPid,
  output logic [CNT_W-1:0]   rspCount,
  output logic               kStateReq
);
  localparam int NUM_EP  = 2;
  localparam int RES_BIT = CNT_W;
  localparam int TX_BIT  = CNT_W + 1;
  localparam int SEL_BIT = CNT_W + 2;

  ctrlStrobe_t      strobe;
  logic [CNT_W+3:0] ctrlReg;

  epresp_ctrl #(.EP_W(EP_W), .NUM_EP(NUM_EP), .EP_BASE(EP_BASE)) uCtrl (
    .regWrEn (regWrEn),
    .tokValid(tokValid),
    .tokEp   (tokEp),
    .bufBusy (bufBusy),
    .epEnable(epEnable),
    .epStall (epStall),
    .txEn    (ctrlReg[TX_BIT]),
    .ownerSel(ctrlReg[SEL_BIT]),
    .strobe  (strobe)
  );

  epresp_datapath #(.CNT_W(CNT_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (regWrData),
    .ctrlReg (ctrlReg),
    .rspValid(rspValid),
    .rspKind (rspKind),
    .rspPid  (rspPid),
    .rspCount(rspCount)
  );

  assign regRdData = ctrlReg;
  assign kStateReq = ctrlReg[RES_BIT];
endmodule

// File: rtl/epresp_checker.sv
module epresp_checker #(
  parameter int CNT_W   = 4,
  parameter int EP_W    = 4,
  parameter int EP_BASE = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [CNT_W+3:0] regWrData,
  input logic [CNT_W+3:0] regRdData,
  input logic             tokValid,
  input logic [EP_W-1:0]  tokEp,
  input logic             bufBusy,
  input logic [1:0]       epEnable,
  input logic [1:0]       epStall,
  input logic             rspValid,
  input logic [1:0]       rspKind,
  input logic             rspPid,
  input logic [CNT_W-1:0] rspCount,
  input logic             kStateReq
);
  logic hitA, hitB;
  assign hitA = tokValid && (tokEp == EP_W'(EP_BASE));
  assign hitB = tokValid && (tokEp == EP_W'(EP_BASE + 1));

  a_r2_readback: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regRdData == $past(regWrData));

  a_r8_valid_after_token: assert property (@(posedge clk) disable iff (!rstN)
    (hitA || hitB) |=> rspValid);

  a_r8_no_stray_valid: assert property (@(posedge clk) disable iff (!rstN)
    !(hitA || hitB) |=> !rspValid);

  a_r6_stall_wins: assert property (@(posedge clk) disable iff (!rstN)
    (hitB && epEnable[1] && epStall[1]) |=> rspKind == 2'b11);

  a_r5_owner_nak: assert property (@(posedge clk) disable iff (!rstN)
    (hitB && epEnable[1] && !epStall[1] && !bufBusy &&
     regRdData[CNT_W+1] && !regRdData[CNT_W+2] && !regWrEn) |=> rspKind == 2'b10);

  a_r7_disabled_silent: assert property (@(posedge clk) disable iff (!rstN)
    (hitA && !epEnable[0]) |=> rspKind == 2'b00);

  a_r9_pid_held: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(regRdData[CNT_W+3]));

  a_r10_kstate: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> kStateReq == $past(regWrData[CNT_W]));

  a_r11_payload_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind != 2'b01) |-> (rspPid == 1'b0 && rspCount == '0));
endmodule

bind shared_ep_in_responder epresp_checker #(.CNT_W(CNT_W), .EP_W(EP_W), .EP_BASE(EP_BASE)) uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
  .regRdData(regRdData), .tokValid(tokValid), .tokEp(tokEp), .bufBusy(bufBusy),
  .epEnable(epEnable), .epStall(epStall), .rspValid(rspValid), .rspKind(rspKind),
  .rspPid(rspPid), .rspCount(rspCount), .kStateReq(kStateReq)
);

// File: tb/sim_shared_ep_in_responder.sv
`timescale 1ns/1ps
module sim_shared_ep_in_responder;
  logic       clk = 1'b0;
  logic       rstN;
  logic       regWrEn;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic       tokValid;
  logic [3:0] tokEp;
  logic       bufBusy;
  logic [1:0] epEnable;
  logic [1:0] epStall;
  logic       rspValid;
  logic [1:0] rspKind;
  logic       rspPid;
  logic [3:0] rspCount;
  logic       kStateReq;

  int nChecks = 0;
  int nFails  = 0;
  bit ended   = 0;

  always #2 clk = ~clk;

  shared_ep_in_responder u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .tokValid(tokValid), .tokEp(tokEp), .bufBusy(bufBusy),
    .epEnable(epEnable), .epStall(epStall), .rspValid(rspValid), .rspKind(rspKind),
    .rspPid(rspPid), .rspCount(rspCount), .kStateReq(kStateReq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  // Expected kind from the requirements: 0 none, 1 DATA, 2 NAK, 3 STALL
  function automatic int expKind(int ep, logic [1:0] en, logic [1:0] st,
                                 logic busy, logic tx, logic sel);
    int idx = ep - 1;
    if (!en[idx]) return 0;
    if (st[idx]) return 3;
    if (!tx || busy) return 2;
    if (int'(sel) != idx) return 2;
    return 1;
  endfunction

  task automatic writeReg(input logic [7:0] v);
    regWrEn = 1'b1; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  initial begin
    #(4.0 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    rstN = 1'b0; regWrEn = 0; regWrData = 0; tokValid = 0; tokEp = 0;
    bufBusy = 0; epEnable = 0; epStall = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(regRdData == 8'h00, "R1 reg", regRdData, 0);
    check(!rspValid, "R1 rspValid", rspValid, 0);
    check(!kStateReq, "R1 kStateReq", kStateReq, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int ep = 0; ep < 4; ep++)
      for (int en = 0; en < 4; en++)
        for (int st = 0; st < 4; st++)
          for (int bz = 0; bz < 2; bz++)
            for (int cfg = 0; cfg < 8; cfg++) begin
              logic [7:0] v;
              logic pid, sel, tx, res;
              int k;
              pid = cfg[2]; sel = cfg[1]; tx = cfg[0];
              res = (ep + en + st) % 2 == 1;
              v = {pid, sel, tx, res, 4'((ep * 7 + en * 5 + st * 3 + bz + cfg) % 16)};
              writeReg(v);
              // R2 / R10
              check(regRdData == v, "R2 readback", regRdData, v);
              check(kStateReq == res, "R10 kStateReq", kStateReq, res);
              tokValid = 1'b1; tokEp = 4'(ep); bufBusy = bz[0];
              epEnable = 2'(en); epStall = 2'(st);
              @(negedge clk);
              tokValid = 1'b0;
              if (ep == 1 || ep == 2) begin
                k = expKind(ep, 2'(en), 2'(st), bz[0], tx, sel);
                // R3..R7 kind; R8 valid
                check(rspValid, "R8 valid after token", rspValid, 1);
                check(int'(rspKind) == k,
                      k == 1 ? "R3 DATA" : k == 3 ? "R6 STALL" : k == 0 ? "R7 timeout" :
                      (tx && !bz[0]) ? "R5 owner NAK" : "R4 NAK", rspKind, k);
                if (k == 1) begin
                  check(rspPid == pid, "R3 pid", rspPid, pid);
                  check(rspCount == v[3:0], "R3 count", rspCount, v[3:0]);
                end else begin
                  check(rspPid == 1'b0 && rspCount == 4'd0, "R11 payload zero",
                        {rspPid, rspCount}, 0);
                end
              end else begin
                check(!rspValid, "R8 other endpoint ignored", rspValid, 0);
              end
              @(negedge clk);
              check(!rspValid, "R8 one-cycle valid", rspValid, 0);
              check(regRdData[7] == pid, "R9 pid unchanged", regRdData[7], pid);
            end

    // R3 zero-length packet and R9 across repeated DATA
    writeReg(8'b1110_0000);
    epEnable = 2'b11; epStall = 2'b00; bufBusy = 0;
    for (int i = 0; i < 3; i++) begin
      tokValid = 1'b1; tokEp = 4'd2;
      @(negedge clk);
      tokValid = 1'b0;
      check(rspKind == 2'b01 && rspCount == 0, "R3 zero length", rspCount, 0);
      check(rspPid == 1'b1, "R9 pid kept", rspPid, 1);
    end
    // R1 reset again clears state
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check(regRdData == 8'h00, "R1 reset clears reg", regRdData, 0);
    check(!kStateReq, "R1 reset clears resume", kStateReq, 0);
    finishRun();
  end
endmodule